// File: doc/BRIEF.md
# Video Pixel Output FIFO Controller

This block sits between a pixel source and an external receiver that runs on its own clock. Samples arrive on a write clock together with a qualifier that marks active-video pixels and control codes. Only qualified samples are stored, in a 512-entry dual-clock FIFO. The read side runs on a separate, faster output clock. Pointers cross between the two domains as Gray codes through two-flop synchronizers.

Two read-control modes are offered. In the self-controlled mode the block drains the FIFO itself. Once the fill level reaches the almost-full threshold, the data-valid flag rises and the FIFO is read on every output clock until it is empty. A qualified strobe marks each cycle that carries a fresh word. In the externally controlled mode the receiver watches the almost-full and almost-empty flags and drives the read request itself, and the strobe is held high. The active level of the two fill flags, and separately the active level of the data-valid flag, can be configured.

Top module: `pix_out_fifo`

## Requirements
- R1: A sample is stored only in a write-clock cycle where both pix_vld_i and pix_act_i are 1. All other samples are discarded.
- R2: The FIFO holds 512 words. A store attempted while it is full is dropped and sets ovf_o. ovf_o stays set until ovf_clr_i is pulsed, and a new drop in the same cycle as a clear wins.
- R3: Words appear on pix_o in the order they were stored, with none lost or repeated.
- R4: In self mode (mode_i=1), the internal data-valid flag and the almost-full flag become active in the same output-clock cycle. The data-valid flag then stays active, and the FIFO is read every cycle, until the FIFO is empty.
- R5: In self mode, the first word of a burst is on pix_o with qclk_o=1 two output-clock cycles after the data-valid flag becomes active. qclk_o is 1 only in cycles carrying a new word, and it stays 0 before the first burst.
- R6: In external mode (mode_i=0), an rd_i sampled at an output-clock edge while the FIFO holds data places the next word on pix_o two edges later. The data-valid flag is active in that cycle, and qclk_o is constantly 1.
- R7: In external mode, rd_i while the FIFO is empty is ignored: the data-valid flag stays inactive and pix_o keeps its last value.
- R8: The almost-full flag is active when the read-side fill level is at least afull_thr_i. The almost-empty flag is active when the level is at most aempty_thr_i.
- R9: flag_pol_i=1 makes both fill flags active-high and flag_pol_i=0 makes them active-low. dv_pol_i selects the active level of dv_o in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Pixel write clock |
| rclk_i | input | 1 | Output read clock, asynchronous to wclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| pix_i | input | PIX_W | Pixel or control code to store |
| pix_vld_i | input | 1 | Sample present this write cycle |
| pix_act_i | input | 1 | Sample is active video or a control code |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag (write domain) |
| ovf_o | output | 1 | Sticky overflow flag (write domain) |
| mode_i | input | 1 | 1 = self-controlled burst reads, 0 = external read request |
| flag_pol_i | input | 1 | Active level of aff_o and aef_o |
| dv_pol_i | input | 1 | Active level of dv_o |
| afull_thr_i | input | log2(DEPTH)+1 | Almost-full threshold in words |
| aempty_thr_i | input | log2(DEPTH)+1 | Almost-empty threshold in words |
| rd_i | input | 1 | External read request (external mode) |
| pix_o | output | PIX_W | Output word |
| dv_o | output | 1 | Data-valid flag |
| qclk_o | output | 1 | Qualified strobe in the read domain |
| aff_o | output | 1 | Almost-full flag |
| aef_o | output | 1 | Almost-empty flag |

## Verification
The assertions assume three things about the inputs. afull_thr_i is at least 1. mode_i changes only while the FIFO is empty and no read is in flight. The output clock outruns the average rate of stored samples. The stimulus keeps to these: the almost-full threshold is fixed at 384 and the almost-empty threshold at 64, the mode changes only after a full drain and a settling gap, and the output clock period is shorter than the write clock period. Fill flags are compared only once the writes have stopped and the pointers have had time to cross the domains, since the read-side level lags the writes by design.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  localparam int PIX_W_DEF = 10;
  localparam int DEPTH_DEF = 512;

  typedef enum logic {
    RD_EXT  = 1'b0,
    RD_SELF = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pfifo_ram.sv
module pfifo_ram #(
  parameter int W     = 10,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rclk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/pfifo_wr_ctl.sv
module pfifo_wr_ctl #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] rgray_i,
  input  logic          ovf_clr_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          ovf_o
);
  logic [PW-1:0] wbin_q, rbin, wbin_nx;
  logic          full;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_i >> i);
  end

  // conservative: rgray_i lags the true read pointer
  assign full    = (wbin_q - rbin) == PW'(DEPTH);
  assign we_o    = push_i & ~full;
  assign wbin_nx = wbin_q + PW'(we_o);
  assign waddr_o = wbin_q[AW-1:0];

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_o <= wbin_nx ^ (wbin_nx >> 1);
      if (push_i && full) ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end

  // R2
  ovf_set_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (push_i && full) |=> ovf_o);
  // R2
  ovf_sticky_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  // R2
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin_q - rbin) <= PW'(DEPTH));
endmodule

// File: rtl/pfifo_rd_ctl.sv
module pfifo_rd_ctl
  import pfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] wgray_i,
  input  logic          mode_i,
  input  logic          rd_i,
  input  logic [PW-1:0] afull_thr_i,
  input  logic [PW-1:0] aempty_thr_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic          aff_o,
  output logic          aef_o,
  output logic          burst_o,
  output logic          vld1_o,
  output logic          vld2_o
);
  logic [PW-1:0] rbin_q, wbin, rbin_nx, level;
  logic          empty, self_md, burst_nx;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_i >> i);
  end

  assign self_md = (mode_i == RD_SELF);
  assign level   = wbin - rbin_q;
  assign empty   = (level == '0);
  assign re_o    = ~empty & (self_md ? burst_o : rd_i);
  assign rbin_nx = rbin_q + PW'(re_o);
  assign raddr_o = rbin_q[AW-1:0];

  always_comb begin
    if (!self_md)     burst_nx = 1'b0;
    else if (burst_o) burst_nx = ~empty;
    else              burst_nx = (level >= afull_thr_i);
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
      aff_o   <= 1'b0;
      aef_o   <= 1'b1;
      burst_o <= 1'b0;
      vld1_o  <= 1'b0;
      vld2_o  <= 1'b0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_o <= rbin_nx ^ (rbin_nx >> 1);
      aff_o   <= (level >= afull_thr_i);
      aef_o   <= (level <= aempty_thr_i);
      burst_o <= burst_nx;
      vld1_o  <= re_o;
      vld2_o  <= vld1_o;
    end
  end

  // R5
  burst_lead_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (self_md && $rose(burst_o)) |-> ##2 vld2_o);
  // R4
  burst_end_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ($fell(burst_o) && $past(self_md)) |-> $past(empty));
  // R4
  burst_with_aff_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (self_md && $rose(burst_o)) |-> aff_o);
  // R3
  level_bound_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    level <= PW'(DEPTH));
endmodule

// File: rtl/pix_out_fifo.sv
module pix_out_fifo
  import pfifo_pkg::*;
#(
  parameter int PIX_W = PIX_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_vld_i,
  input  logic             pix_act_i,
  input  logic             ovf_clr_i,
  output logic             ovf_o,
  input  logic             mode_i,
  input  logic             flag_pol_i,
  input  logic             dv_pol_i,
  input  logic [PW-1:0]    afull_thr_i,
  input  logic [PW-1:0]    aempty_thr_i,
  input  logic             rd_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             dv_o,
  output logic             qclk_o,
  output logic             aff_o,
  output logic             aef_o
);
  logic             push, we, re, aff_raw, aef_raw, burst, vld1, vld2, dv_raw;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
  logic [PIX_W-1:0] ram_q, pix_q;

  assign push = pix_vld_i & pix_act_i;

  pfifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk_i, .rst_ni, .push_i(push), .rgray_i(rgray_s), .ovf_clr_i,
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray), .ovf_o
  );

  pfifo_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni, .d_i(wgray), .q_o(wgray_s));
  pfifo_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni, .d_i(rgray), .q_o(rgray_s));

  pfifo_ram #(.W(PIX_W), .DEPTH(DEPTH)) u_ram (
    .wclk_i, .we_i(we), .waddr_i(waddr), .wdata_i(pix_i),
    .rclk_i, .re_i(re), .raddr_i(raddr), .rdata_o(ram_q)
  );

  pfifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .rclk_i, .rst_ni, .wgray_i(wgray_s), .mode_i, .rd_i, .afull_thr_i, .aempty_thr_i,
    .re_o(re), .raddr_o(raddr), .rgray_o(rgray), .aff_o(aff_raw), .aef_o(aef_raw),
    .burst_o(burst), .vld1_o(vld1), .vld2_o(vld2)
  );

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   pix_q <= '0;
    else if (vld1) pix_q <= ram_q;
  end

  assign pix_o  = pix_q;
  assign dv_raw = (mode_i == RD_SELF) ? burst : vld2;
  assign dv_o   = dv_pol_i ? dv_raw : ~dv_raw;
  assign qclk_o = (mode_i == RD_SELF) ? vld2 : 1'b1;
  assign aff_o  = flag_pol_i ? aff_raw : ~aff_raw;
  assign aef_o  = flag_pol_i ? aef_raw : ~aef_raw;

  // R1
  drop_inactive_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !push |=> $stable(wgray));
  // R7
  hold_out_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !vld1 |=> $stable(pix_o));
endmodule

// File: tb/sim_pix_out_fifo.sv
module sim_pix_out_fifo;
  localparam int PW = 10;

  logic          wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic [9:0]    pix = '0;
  logic          pix_vld = 1'b0, pix_act = 1'b0, ovf_clr = 1'b0;
  logic          mode = 1'b0, flag_pol = 1'b1, dv_pol = 1'b1, rd = 1'b0;
  logic [PW-1:0] afull_thr = PW'(384), aempty_thr = PW'(64);
  logic          ovf_o, dv_o, qclk_o, aff_o, aef_o;
  logic [9:0]    pix_o;

  always #4 wclk = ~wclk;
  always #3 rclk = ~rclk;

  pix_out_fifo u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni, .pix_i(pix), .pix_vld_i(pix_vld),
    .pix_act_i(pix_act), .ovf_clr_i(ovf_clr), .ovf_o, .mode_i(mode),
    .flag_pol_i(flag_pol), .dv_pol_i(dv_pol), .afull_thr_i(afull_thr),
    .aempty_thr_i(aempty_thr), .rd_i(rd), .pix_o, .dv_o, .qclk_o, .aff_o, .aef_o
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [9:0] exp_q[$];
  int  rise_cnt = -1, fell_cnt = 0, self_pops = 0;
  bit  dv_prev = 1'b0, burst_seen = 1'b0, first_pend = 1'b0;

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic pop_cmp(input string tag);
    if (exp_q.size() == 0) chk({tag, " unexpected word"}, 1, 0);
    else chk(tag, int'(pix_o), int'(exp_q.pop_front()));
  endtask

  // reference monitor, every output clock
  always @(negedge rclk) begin
    if (rst_ni && !done) begin
      bit dv_act;
      dv_act = (dv_o == dv_pol);
      if (!mode) begin
        chk("R6 qclk continuous", int'(qclk_o), 1);
        if (dv_act) pop_cmp("R3 ext order");
      end else begin
        if (dv_act && !dv_prev) begin
          chk("R4 dv with aff", int'(aff_o == flag_pol), 1);
          rise_cnt = 0; first_pend = 1'b1; burst_seen = 1'b1;
        end else if (rise_cnt >= 0) rise_cnt++;
        if (qclk_o) begin
          if (!burst_seen) chk("R5 strobe before burst", 1, 0);
          if (first_pend) begin
            chk("R5 dv lead", rise_cnt, 2);
            first_pend = 1'b0;
          end
          self_pops++;
          pop_cmp("R3 self order");
        end
        if (!dv_act && dv_prev) fell_cnt++;
      end
      dv_prev = dv_act;
    end
  end

  task automatic wr_px(input bit v, input bit a, input logic [9:0] d);
    @(negedge wclk);
    pix_vld = v; pix_act = a; pix = d;
    if (v && a && exp_q.size() < 512) exp_q.push_back(d);
  endtask

  task automatic wr_idle();
    @(negedge wclk);
    pix_vld = 1'b0; pix_act = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic rd_burst(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge rclk); rd = 1'b1;
    end
    @(negedge rclk); rd = 1'b0;
    repeat (4) @(negedge rclk);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    chk("watchdog", 1, 0);
    finish_tb();
  end

  initial begin
    int acc;
    logic [9:0] last;
    repeat (3) @(negedge wclk);
    rst_ni = 1'b1;
    repeat (2) @(negedge rclk);
    // reset state
    chk("R8 reset aff", int'(aff_o), 0);
    chk("R8 reset aef", int'(aef_o), 1);
    chk("R9 reset dv", int'(dv_o), 0);
    chk("R6 reset qclk", int'(qclk_o), 1);
    chk("R2 reset ovf", int'(ovf_o), 0);

    // R1: mixed qualifier patterns
    for (int i = 0; i < 60; i++)
      wr_px((i % 2 == 0) || (i % 5 == 0), (i % 3) != 1, 10'(i * 7 + 3));
    wr_idle(); settle();
    acc = exp_q.size();
    chk("R1 accepted count small", int'(acc <= 64), 1);
    chk("R8 aef low level", int'(aef_o), 1);
    chk("R8 aff low level", int'(aff_o), 0);
    for (int i = 60; i < 260; i++)
      wr_px((i % 2 == 0) || (i % 5 == 0), (i % 3) != 1, 10'(i * 7 + 3));
    wr_idle(); settle();
    acc = exp_q.size();
    chk("R8 aef mid level", int'(aef_o), int'(acc <= 64));
    chk("R8 aff mid level", int'(aff_o), int'(acc >= 384));
    flag_pol = 1'b0;
    @(negedge rclk);
    chk("R9 aff active-low", int'(aff_o), 1);
    chk("R9 aef active-low", int'(aef_o), 1);
    flag_pol = 1'b1;

    // R6: latency of a single external read
    @(negedge rclk); rd = 1'b1;
    @(negedge rclk); rd = 1'b0;
    chk("R6 no data after one edge", int'(dv_o), 0);
    @(negedge rclk);
    chk("R6 data after two edges", int'(dv_o), 1);
    rd_burst(acc - 1);
    chk("R3 ext drained", exp_q.size(), 0);

    // R7: reads on an empty FIFO
    last = pix_o;
    for (int k = 0; k < 5; k++) begin
      @(negedge rclk); rd = 1'b1;
      @(negedge rclk); rd = 1'b0;
      @(negedge rclk);
      chk("R7 dv idle on empty read", int'(dv_o), 0);
      chk("R7 pix_o held", int'(pix_o), int'(last));
    end

    // R2: overflow
    for (int i = 0; i < 520; i++) wr_px(1'b1, 1'b1, 10'(i * 13 + 5));
    wr_idle(); settle();
    chk("R2 ovf set", int'(ovf_o), 1);
    chk("R2 model depth", exp_q.size(), 512);
    chk("R8 aff full", int'(aff_o), 1);
    chk("R8 aef full", int'(aef_o), 0);
    @(negedge wclk); ovf_clr = 1'b1;
    @(negedge wclk); ovf_clr = 1'b0;
    chk("R2 ovf cleared", int'(ovf_o), 0);
    dv_pol = 1'b0;
    @(negedge rclk);
    chk("R9 dv active-low idle", int'(dv_o), 1);
    rd_burst(512);
    chk("R3 full drain", exp_q.size(), 0);
    chk("R2 ovf stays clear", int'(ovf_o), 0);

    // R4/R5: self-controlled bursts
    settle();
    mode = 1'b1;
    settle();
    for (int i = 0; i < 390; i++) wr_px(1'b1, 1'b1, 10'(i * 3 + 1));
    wr_idle();
    for (int k = 0; k < 4000 && fell_cnt == 0; k++) @(negedge rclk);
    repeat (4) @(negedge rclk);
    chk("R4 burst ended", fell_cnt, 1);
    chk("R4 drained to empty", exp_q.size(), 0);
    chk("R4 burst word count", self_pops, 390);
    chk("R5 strobe idle after drain", int'(qclk_o), 0);
    chk("R8 aef after drain", int'(aef_o), 1);
    finish_tb();
  end
endmodule